// File: doc/BRIEF.md
# LFSR-Sequenced Clock Divider

This block produces a slow clock from a fast one. One output period spans `DIV_RATIO` input clock cycles. The counter behind it is a maximal-length linear-feedback shift register rather than a binary adder, so its next-state logic is a shift and a handful of XOR gates at any width. The register is forced back to its first state after exactly `DIV_RATIO` states. The output is high for the first `HIGH_CYCLES` positions of each period and low for the rest. If `HIGH_CYCLES` is left at its default, it is half the ratio, rounded down.

Two preset controls place the counter at a chosen point of the period, given as a position in the sequence rather than as a raw register value:
- The level-sensitive asynchronous preset acts at once and also serves as the block's reset.
- The synchronous preset acts on an enabled rising edge.

A clock enable freezes the whole block while it is low. Positions are mapped to register states during elaboration. Illegal parameter combinations stop elaboration: the ratio must lie between 2 and 65535, the high time must satisfy 1 ≤ `HIGH_CYCLES` < `DIV_RATIO`, and each preset position must be below `DIV_RATIO`.

Top module: `lfsr_clk_divider`

## Requirements
- R1: With `clk_en` held high and both presets low, the sequence position advances by one per rising edge. Position `DIV_RATIO-1` is followed by position 0, so `div_clk` repeats every `DIV_RATIO` cycles.
- R2: `div_clk` is high exactly while the current position is below `HIGH_CYCLES`, and low for the other positions. It is a registered output that changes only on clock edges or on the asynchronous preset.
- R3: When `HIGH_CYCLES` is not overridden it equals `DIV_RATIO/2`, rounded down. An odd ratio therefore gives one more low cycle than high cycles.
- R4: While `preset_async` is high, the position is position `APRESET_POS` without waiting for a clock edge, whatever the level of `clk_en`. `div_clk` follows as in R2. After release, counting resumes from that position.
- R5: A rising edge with `preset_sync` and `clk_en` both high sets the position to `SPRESET_POS`. If `preset_sync` is high while `clk_en` is low, it has no effect.
- R6: While `clk_en` is low, neither the position nor `div_clk` changes.
- R7: `preset_async` overrides `preset_sync`, and `preset_sync` overrides normal counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, rising edge active |
| clk_en | input | 1 | Step enable; tie high when not used |
| preset_async | input | 1 | Level-sensitive preset to position `APRESET_POS`, also the reset |
| preset_sync | input | 1 | Preset to position `SPRESET_POS` on an enabled edge |
| div_clk | output | 1 | Divided clock output |

## Verification
Three functions can collide on one edge:
- The wrap from the last position back to position 0 can meet a synchronous preset.
- A synchronous preset can be blocked by a low enable.
- An asynchronous preset can be held across an edge where the synchronous preset is also requested.

The bench drives each of these collisions on five divider instances with different ratios and preset positions, so the period boundary and the preset fall at different phases in each instance. A binary position model applies the R7 priority order, and its output is compared with every instance after each edge. The immediate effect of the asynchronous preset is checked separately, partway through a cycle, before the next edge arrives.

// File: rtl/ldiv_pkg.sv
package ldiv_pkg;

    localparam int unsigned MAX_W = 16;
    typedef logic [MAX_W-1:0] wide_t;

    // Smallest register width whose maximal sequence covers n states.
    function automatic int unsigned lfsr_width(input int unsigned n);
        for (int unsigned w = 2; w <= MAX_W; w++) begin
            if (((32'd1 << w) - 32'd1) >= n) return w;
        end
        return MAX_W;
    endfunction

    // Feedback taps of a maximal-length sequence for each width.
    function automatic wide_t tap_mask(input int unsigned w);
        case (w)
            2:       return 16'h0003;
            3:       return 16'h0006;
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            11:      return 16'h0500;
            12:      return 16'h0829;
            13:      return 16'h100D;
            14:      return 16'h2015;
            15:      return 16'h6000;
            default: return 16'hD008;
        endcase
    endfunction

    function automatic wide_t step(input wide_t s, input int unsigned w);
        wide_t mask;
        logic  fb;
        mask = wide_t'((32'd1 << w) - 32'd1);
        fb   = ^(s & tap_mask(w));
        return ((s << 1) | wide_t'(fb)) & mask;
    endfunction

    // Register contents at a given position; position 0 is the seed 1.
    function automatic wide_t state_at(input int unsigned pos, input int unsigned w);
        wide_t s;
        s = wide_t'(1);
        for (int unsigned i = 0; i < pos; i++) s = step(s, w);
        return s;
    endfunction

endpackage

// File: rtl/ldiv_lfsr_step.sv
module ldiv_lfsr_step #(
    parameter int unsigned W = 3
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam ldiv_pkg::wide_t TAPS_W = ldiv_pkg::tap_mask(W);
    localparam logic [W-1:0]    TAPS   = TAPS_W[W-1:0];

    assign nxt[0] = ^(cur & TAPS);

    for (genvar i = 1; i < W; i++) begin : g_shift
        assign nxt[i] = cur[i-1];
    end
endmodule

// File: rtl/ldiv_decode.sv
module ldiv_decode #(
    parameter int unsigned   W          = 3,
    parameter logic [W-1:0]  LAST_ST    = '0,
    parameter logic [W-1:0]  PRE_HI_END = '0
) (
    input  logic [W-1:0] cur,
    output logic         at_last,
    output logic         at_pre_low
);
    // at_last: next enabled step wraps to position 0.
    // at_pre_low: next enabled step enters the first low position.
    assign at_last    = (cur == LAST_ST);
    assign at_pre_low = (cur == PRE_HI_END);
endmodule

// File: rtl/lfsr_clk_divider.sv
module lfsr_clk_divider #(
    parameter int unsigned DIV_RATIO   = 6,
    parameter int unsigned HIGH_CYCLES = DIV_RATIO / 2,
    parameter int unsigned APRESET_POS = 0,
    parameter int unsigned SPRESET_POS = 0
) (
    input  logic clk,
    input  logic clk_en,
    input  logic preset_async,
    input  logic preset_sync,
    output logic div_clk
);
    localparam int unsigned W = ldiv_pkg::lfsr_width(DIV_RATIO);

    localparam ldiv_pkg::wide_t FIRST_W  = ldiv_pkg::state_at(0, W);
    localparam ldiv_pkg::wide_t LAST_W   = ldiv_pkg::state_at(DIV_RATIO - 1, W);
    localparam ldiv_pkg::wide_t PRELOW_W = ldiv_pkg::state_at(HIGH_CYCLES - 1, W);
    localparam ldiv_pkg::wide_t ASYNC_W  = ldiv_pkg::state_at(APRESET_POS, W);
    localparam ldiv_pkg::wide_t SYNC_W   = ldiv_pkg::state_at(SPRESET_POS, W);

    localparam logic [W-1:0] S_FIRST  = FIRST_W[W-1:0];
    localparam logic [W-1:0] S_LAST   = LAST_W[W-1:0];
    localparam logic [W-1:0] S_PRELOW = PRELOW_W[W-1:0];
    localparam logic [W-1:0] S_ASYNC  = ASYNC_W[W-1:0];
    localparam logic [W-1:0] S_SYNC   = SYNC_W[W-1:0];
    localparam logic         ASYNC_HI = (APRESET_POS < HIGH_CYCLES);
    localparam logic         SYNC_HI  = (SPRESET_POS < HIGH_CYCLES);

    if (DIV_RATIO < 2 || DIV_RATIO > 65535) begin : g_bad_ratio
        $error("lfsr_clk_divider: DIV_RATIO out of range");
    end
    if (HIGH_CYCLES < 1 || HIGH_CYCLES >= DIV_RATIO) begin : g_bad_high
        $error("lfsr_clk_divider: HIGH_CYCLES must be in 1..DIV_RATIO-1");
    end
    if (APRESET_POS >= DIV_RATIO || SPRESET_POS >= DIV_RATIO) begin : g_bad_pos
        $error("lfsr_clk_divider: preset position beyond the period");
    end

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         hi;
    } div_state_t;

    div_state_t   st_d, st_q;
    logic [W-1:0] step_nxt;
    logic         at_last, at_pre_low;

    ldiv_lfsr_step #(.W(W)) i_step (
        .cur (st_q.cnt),
        .nxt (step_nxt)
    );

    ldiv_decode #(
        .W          (W),
        .LAST_ST    (S_LAST),
        .PRE_HI_END (S_PRELOW)
    ) i_decode (
        .cur        (st_q.cnt),
        .at_last    (at_last),
        .at_pre_low (at_pre_low)
    );

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (preset_sync) begin
                st_d.cnt = S_SYNC;
                st_d.hi  = SYNC_HI;
            end else if (at_last) begin
                st_d.cnt = S_FIRST;
                st_d.hi  = 1'b1;
            end else begin
                st_d.cnt = step_nxt;
                if (at_pre_low) st_d.hi = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or posedge preset_async) begin
        if (preset_async) begin
            st_q.cnt <= S_ASYNC;
            st_q.hi  <= ASYNC_HI;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk = st_q.hi;

    // R1: register never enters the all-zero lock-up state
    a_r1_no_lockup: assert property (@(posedge clk) disable iff (preset_async)
        st_q.cnt != '0);

    // R1: last position is followed by position 0 with the output high
    a_r1_wrap: assert property (@(posedge clk) disable iff (preset_async)
        (clk_en && !preset_sync && st_q.cnt == S_LAST) |=> (st_q.cnt == S_FIRST && div_clk));

    // R2: position 0 always drives the output high
    a_r2_first_high: assert property (@(posedge clk) disable iff (preset_async)
        (st_q.cnt == S_FIRST) |-> div_clk);

    // R5: enabled synchronous preset lands on its position
    a_r5_sync_load: assert property (@(posedge clk) disable iff (preset_async)
        (clk_en && preset_sync) |=> (st_q.cnt == S_SYNC && div_clk == SYNC_HI));

    // R6: disabled edge changes nothing
    a_r6_hold: assert property (@(posedge clk) disable iff (preset_async)
        !clk_en |=> ($stable(st_q.cnt) && $stable(div_clk)));

endmodule

// File: tb/test_lfsr_clk_divider.sv
`timescale 1ns/1ps
module test_lfsr_clk_divider;

    localparam int N = 5;
    localparam int DV [N] = '{6, 7, 5, 2, 20};
    localparam int DU [N] = '{3, 3, 1, 1, 13};
    localparam int AP [N] = '{0, 2, 4, 1, 17};
    localparam int SP [N] = '{0, 5, 1, 0, 9};

    logic clk = 1'b0;
    logic clk_en = 1'b1;
    logic preset_async = 1'b0;
    logic preset_sync = 1'b0;
    logic [N-1:0] outs;

    always #2.5 clk = ~clk;

    // instances 0 and 1 keep the default high time (R3)
    lfsr_clk_divider #(.DIV_RATIO(DV[0]), .APRESET_POS(AP[0]), .SPRESET_POS(SP[0]))
        i_lfsr_clk_divider (.clk(clk), .clk_en(clk_en), .preset_async(preset_async),
                            .preset_sync(preset_sync), .div_clk(outs[0]));
    lfsr_clk_divider #(.DIV_RATIO(DV[1]), .APRESET_POS(AP[1]), .SPRESET_POS(SP[1]))
        i_lfsr_clk_divider_1 (.clk(clk), .clk_en(clk_en), .preset_async(preset_async),
                              .preset_sync(preset_sync), .div_clk(outs[1]));
    lfsr_clk_divider #(.DIV_RATIO(DV[2]), .HIGH_CYCLES(DU[2]), .APRESET_POS(AP[2]), .SPRESET_POS(SP[2]))
        i_lfsr_clk_divider_2 (.clk(clk), .clk_en(clk_en), .preset_async(preset_async),
                              .preset_sync(preset_sync), .div_clk(outs[2]));
    lfsr_clk_divider #(.DIV_RATIO(DV[3]), .HIGH_CYCLES(DU[3]), .APRESET_POS(AP[3]), .SPRESET_POS(SP[3]))
        i_lfsr_clk_divider_3 (.clk(clk), .clk_en(clk_en), .preset_async(preset_async),
                              .preset_sync(preset_sync), .div_clk(outs[3]));
    lfsr_clk_divider #(.DIV_RATIO(DV[4]), .HIGH_CYCLES(DU[4]), .APRESET_POS(AP[4]), .SPRESET_POS(SP[4]))
        i_lfsr_clk_divider_4 (.clk(clk), .clk_en(clk_en), .preset_async(preset_async),
                              .preset_sync(preset_sync), .div_clk(outs[4]));

    typedef struct {
        logic [N-1:0] exp;
        string        tag;
    } item_t;

    item_t q[$];
    int    pos [N];
    int    checks = 0;
    int    errors = 0;

    function automatic logic [N-1:0] exp_out();
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = (pos[k] < DU[k]);
        return v;
    endfunction

    // reference position model, binary count, priority async > sync > count
    function automatic void model_edge(input logic a, input logic s, input logic e);
        for (int k = 0; k < N; k++) begin
            if (a)      pos[k] = AP[k];
            else if (e) pos[k] = s ? SP[k] : ((pos[k] == DV[k] - 1) ? 0 : pos[k] + 1);
        end
    endfunction

    task automatic check(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: div_clk vector actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // driver: applies inputs at a falling edge and queues the result of the next rising edge
    task automatic drive(input logic a, input logic s, input logic e, input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            preset_async = a;
            preset_sync  = s;
            clk_en       = e;
            model_edge(a, s, e);
            q.push_back('{exp_out(), tag});
        end
    endtask

    // asynchronous preset raised mid-cycle, checked before any edge
    task automatic async_mid();
        @(negedge clk);
        #1;
        preset_async = 1'b1;
        for (int k = 0; k < N; k++) pos[k] = AP[k];
        #0.5;
        check(outs, exp_out(), "R4 immediate preset");
        q.push_back('{exp_out(), "R4 preset held over edge"});
    endtask

    // monitor: compares after each rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(outs, it.exp, it.tag);
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual running expected done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < N; k++) pos[k] = AP[k];
        #0.5 preset_async = 1'b1;
        drive(1, 0, 1, "R4 reset position", 3);
        drive(0, 0, 1, "R1 R2 R3 free run", 45);
        for (int i = 0; i < 24; i++) drive(0, 0, (i % 3) != 0, "R6 enable stall", 1);
        drive(0, 1, 0, "R5 sync ignored while disabled", 4);
        drive(0, 1, 1, "R5 sync load", 1);
        drive(0, 0, 1, "R1 wrap after sync load", 25);
        drive(0, 1, 1, "R5 sync held", 3);
        drive(0, 0, 1, "R1 resume", 10);
        async_mid();
        drive(1, 0, 1, "R4 preset held", 3);
        drive(1, 1, 1, "R7 async over sync", 3);
        drive(1, 0, 0, "R4 preset with enable low", 2);
        drive(0, 0, 1, "R4 resume after release", 7);
        drive(0, 1, 1, "R7 sync over count", 1);
        drive(0, 0, 1, "R7 after sync", 30);
        drive(0, 0, 0, "R6 final stall", 4);
        wait (q.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule